// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is one DMA channel that follows a chain of descriptors held in memory and copies data from a source region to a destination region, one 32-bit word per beat. Software first writes the address of the first descriptor and turns the channel on. A write to the kick register then starts the channel. For each descriptor the channel reads eight words, checks the valid flag in the command word and copies the requested number of bytes. It can then write a status word back into the descriptor and clear the descriptor's valid flag. After that it sets the pending flag and moves on to the next descriptor, whose address comes from the descriptor's link word.

The channel stops and reports halted when it fetches a descriptor with the valid flag clear. Its pointer register then holds that descriptor's address, so software can fill in the descriptor and kick the channel again to resume the chain. The channel has a small register file and one word-wide memory master port with a request/grant handshake. Read data is returned in the cycle the grant is given.

Top module: `dmaseq_chan`

## Requirements
- R1: After reset the status register (index 4) reads 1, meaning halted with the doorbell flag and the valid flag clear. The pending register (index 3), the remaining-count register (index 5) and `irq_o` all read 0.
- R2: A write to the kick register (index 2) starts the channel only if bit 0 of the control register (index 0) is 1 and the channel is halted. A kick while the channel is disabled causes no memory request, and the status register stays at 1.
- R3: When `mem_req` is high and `mem_gnt` is low, the request, its address and its direction stay the same on the next cycle.
- R4: A descriptor is read as eight words starting at the pointer, which must be 32-byte aligned. Word 0 is the command word, word 1 the count word, word 2 the source, word 4 the destination and word 7 the link.
- R5: The copy reads the source and writes the destination in ascending word order. It makes ceil(N/4) beats, where N is bits 21:0 of the count word, limited to the count width. A count of zero copies nothing.
- R6: If the command word fetched has bit 31 (valid) clear, the channel halts. The status register then reads 1, with the doorbell flag (bit 2) and the valid flag (bit 1) both clear. The pointer register (index 1) then reads that descriptor's address.
- R7: Bits 1:0 of the command word choose the write-back to descriptor offset 0x18 once the copy is done. 0 writes nothing. 1 writes the live status word, which is 6 while a descriptor is running. 2 writes the command word with bit 31 cleared. 3 writes the remaining byte count.
- R8: If bit 2 of the command word is set, the channel writes the command word with bit 31 cleared to the descriptor's own address. This write comes after any write-back.
- R9: Each completed descriptor sets bit 0 of the pending register. `irq_o` is high only while that flag is set and the last completed descriptor had bit 8 of its command word set. Writing 0 to bit 0 clears both.
- R10: The address of the next descriptor is bits 26:0 of the link word shifted left by 5. The remaining-count register reads 0 once the chain has halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the channel with a 16-bit address, a 12-bit count field and status write-back enabled. With these values one small model memory holds all the descriptors and buffers, and the shorter count path is exercised. A pseudo-random grant pattern inserts stalls on fetch, copy and write-back beats, which stresses the requirement that requests are held. Two chains between them cover every write-back mode, clear-valid, a count that is not a multiple of four, a zero count, halting and resuming on an invalid descriptor, and interrupt gating.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_CHECK, ST_RD, ST_WR, ST_WB, ST_CLRV, ST_NEXT
   } dq_state_e;

   localparam int DESC_WORDS  = 8;
   localparam int VALID_BIT   = 31;
   localparam int IE_BIT      = 8;
   localparam int CLRV_BIT    = 2;
   localparam int LINK_SHIFT  = 5;

   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_PTR  = 3'd1;
   localparam logic [2:0] RA_KICK = 3'd2;
   localparam logic [2:0] RA_PEND = 3'd3;
   localparam logic [2:0] RA_STAT = 3'd4;
   localparam logic [2:0] RA_LEFT = 3'd5;

   localparam logic [4:0] STAT_OFS = 5'h18;
endpackage

// File: rtl/dmaseq_wbsel.sv
module dmaseq_wbsel #(
   parameter int CNT_W     = 22,
   parameter bit STATUS_WB = 1'b1
) (
   input  logic [1:0]       mode,
   input  logic [2:0]       stat,
   input  logic [31:0]      cmd0,
   input  logic [CNT_W-1:0] remain,
   output logic             en,
   output logic [31:0]      word
);
   import dmaseq_pkg::*;

   generate
      if (STATUS_WB) begin : g_wb
         always_comb begin
            en   = (mode != 2'd0);
            word = '0;
            case (mode)
               2'd1:    word = 32'(stat);
               2'd2:    word = cmd0 & ~(32'd1 << VALID_BIT);
               2'd3:    word = 32'(remain);
               default: word = '0;
            endcase
         end
      end else begin : g_nowb
         assign en   = 1'b0;
         assign word = '0;
      end
   endgenerate
endmodule

// File: rtl/dmaseq_engine.sv
module dmaseq_engine #(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 22,
   parameter bit STATUS_WB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick,
   input  logic              ptr_ld,
   input  logic [ADDR_W-1:0] ptr_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [31:0]       mem_rdata,
   output logic              halted,
   output logic              db_flag,
   output logic              desc_vld,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [CNT_W-1:0]  remain,
   output logic              done,
   output logic              done_ie
);
   import dmaseq_pkg::*;

   localparam int IDX_W  = $clog2(DESC_WORDS);
   localparam int LINK_W = ADDR_W - LINK_SHIFT;
   localparam logic [CNT_W-1:0] BEAT = CNT_W'(4);

   dq_state_e          st;
   logic [IDX_W-1:0]   idx;
   logic [31:0]        cmd0;
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  src, dst;
   logic [LINK_W-1:0]  link;
   logic [31:0]        beat_buf;
   logic               wb_en, clrv;
   logic [31:0]        wb_word;
   logic [2:0]         stat_now;

   assign halted   = (st == ST_IDLE);
   assign stat_now = {db_flag, desc_vld, halted};
   assign clrv     = cmd0[CLRV_BIT];
   assign done     = (st == ST_NEXT);
   assign done_ie  = cmd0[IE_BIT];

   dmaseq_wbsel #(.CNT_W(CNT_W), .STATUS_WB(STATUS_WB)) u_wbsel (
      .mode(cmd0[1:0]), .stat(stat_now), .cmd0(cmd0), .remain(remain),
      .en(wb_en), .word(wb_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         idx      <= '0;
         cmd0     <= '0;
         cnt      <= '0;
         src      <= '0;
         dst      <= '0;
         link     <= '0;
         beat_buf <= '0;
         cur_ptr  <= '0;
         remain   <= '0;
         db_flag  <= 1'b0;
         desc_vld <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (ptr_ld) cur_ptr <= ptr_wdata;
               if (kick) begin
                  st      <= ST_FETCH;
                  idx     <= '0;
                  db_flag <= 1'b1;
               end
            end
            ST_FETCH: if (mem_gnt) begin
               case (idx)
                  3'd0: cmd0 <= mem_rdata;
                  3'd1: cnt  <= mem_rdata[CNT_W-1:0];
                  3'd2: src  <= mem_rdata[ADDR_W-1:0];
                  3'd4: dst  <= mem_rdata[ADDR_W-1:0];
                  3'd7: link <= mem_rdata[LINK_W-1:0];
                  default: ;
               endcase
               idx <= idx + 1'b1;
               if (idx == IDX_W'(DESC_WORDS - 1)) st <= ST_CHECK;
            end
            ST_CHECK: begin
               if (!cmd0[VALID_BIT]) begin
                  st       <= ST_IDLE;
                  db_flag  <= 1'b0;
                  desc_vld <= 1'b0;
               end else begin
                  desc_vld <= 1'b1;
                  remain   <= cnt;
                  st       <= (cnt == '0) ? ST_WB : ST_RD;
               end
            end
            ST_RD: if (mem_gnt) begin
               beat_buf <= mem_rdata;
               st       <= ST_WR;
            end
            ST_WR: if (mem_gnt) begin
               src <= src + ADDR_W'(4);
               dst <= dst + ADDR_W'(4);
               if (remain <= BEAT) begin
                  remain <= '0;
                  st     <= ST_WB;
               end else begin
                  remain <= remain - BEAT;
                  st     <= ST_RD;
               end
            end
            ST_WB:   if (!wb_en || mem_gnt) st <= ST_CLRV;
            ST_CLRV: if (!clrv || mem_gnt)  st <= ST_NEXT;
            ST_NEXT: begin
               cur_ptr  <= {link, {LINK_SHIFT{1'b0}}};
               desc_vld <= 1'b0;
               idx      <= '0;
               st       <= ST_FETCH;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (st)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = {cur_ptr[ADDR_W-1:LINK_SHIFT], idx, 2'b00};
         end
         ST_RD: begin
            mem_req  = 1'b1;
            mem_addr = {src[ADDR_W-1:2], 2'b00};
         end
         ST_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {dst[ADDR_W-1:2], 2'b00};
            mem_wdata = beat_buf;
         end
         ST_WB: begin
            mem_req   = wb_en;
            mem_we    = wb_en;
            mem_addr  = {cur_ptr[ADDR_W-1:LINK_SHIFT], STAT_OFS};
            mem_wdata = wb_word;
         end
         ST_CLRV: begin
            mem_req   = clrv;
            mem_we    = clrv;
            mem_addr  = {cur_ptr[ADDR_W-1:LINK_SHIFT], {LINK_SHIFT{1'b0}}};
            mem_wdata = cmd0 & ~(32'd1 << VALID_BIT);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dmaseq_regs.sv
module dmaseq_regs #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              halted,
   input  logic              db_flag,
   input  logic              desc_vld,
   input  logic [ADDR_W-1:0] cur_ptr,
   input  logic [CNT_W-1:0]  remain,
   input  logic              done,
   input  logic              done_ie,
   output logic              kick,
   output logic              ptr_ld,
   output logic [ADDR_W-1:0] ptr_wdata,
   output logic              pend,
   output logic              irq_o
);
   import dmaseq_pkg::*;

   logic en, pend_ie;

   assign kick      = reg_we && (reg_addr == RA_KICK) && en && halted;
   assign ptr_ld    = reg_we && (reg_addr == RA_PTR) && halted;
   assign ptr_wdata = reg_wdata[ADDR_W-1:0];
   assign irq_o     = pend && pend_ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         pend    <= 1'b0;
         pend_ie <= 1'b0;
      end else begin
         if (reg_we && reg_addr == RA_CTRL) en <= reg_wdata[0];
         if (done) begin
            pend    <= 1'b1;
            pend_ie <= done_ie;
         end else if (reg_we && reg_addr == RA_PEND && !reg_wdata[0]) begin
            pend    <= 1'b0;
            pend_ie <= 1'b0;
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_CTRL: reg_rdata = {31'd0, en};
         RA_PTR:  reg_rdata = 32'(cur_ptr);
         RA_PEND: reg_rdata = {31'd0, pend};
         RA_STAT: reg_rdata = {29'd0, db_flag, desc_vld, halted};
         RA_LEFT: reg_rdata = 32'(remain);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dmaseq_chan.sv
module dmaseq_chan #(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 22,
   parameter bit STATUS_WB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [31:0]       mem_rdata,
   output logic              irq_o
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("dmaseq_chan: ADDR_W must be within 8..32");
      end
      if (CNT_W < 3 || CNT_W > 22) begin : g_bad_cnt
         $error("dmaseq_chan: CNT_W must be within 3..22");
      end
   endgenerate

   logic              halted, db_flag, desc_vld, done, done_ie;
   logic              kick, ptr_ld, pend;
   logic [ADDR_W-1:0] cur_ptr, ptr_wdata;
   logic [CNT_W-1:0]  remain;

   dmaseq_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STATUS_WB(STATUS_WB)) u_eng (
      .clk(clk), .rst_n(rst_n), .kick(kick), .ptr_ld(ptr_ld), .ptr_wdata(ptr_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .halted(halted), .db_flag(db_flag), .desc_vld(desc_vld), .cur_ptr(cur_ptr),
      .remain(remain), .done(done), .done_ie(done_ie)
   );

   dmaseq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .halted(halted), .db_flag(db_flag), .desc_vld(desc_vld), .cur_ptr(cur_ptr),
      .remain(remain), .done(done), .done_ie(done_ie),
      .kick(kick), .ptr_ld(ptr_ld), .ptr_wdata(ptr_wdata), .pend(pend), .irq_o(irq_o)
   );
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              irq_o,
   input logic              halted,
   input logic              db_flag,
   input logic              desc_vld,
   input logic              done,
   input logic              pend
);
   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r2_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req);

   a_r9_done_pends: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> pend);

   a_r9_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pend);

   a_r6_halt_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> !db_flag && !desc_vld);
endmodule

bind dmaseq_chan dmaseq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dmaseq_chan_tb.sv
module dmaseq_chan_tb;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_wdata, mem_rdata;
   logic              mem_gnt;
   logic              irq_o;

   logic [31:0] mem [0:255];
   logic [7:0]  lf;
   logic [31:0] exp_a [$];
   logic [31:0] exp_d [$];
   int total = 0, bad = 0, req_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dmaseq_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STATUS_WB(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq_o(irq_o)
   );

   assign mem_rdata = mem[mem_addr[9:2]];
   assign mem_gnt   = lf[0] | lf[1];

   always @(posedge clk) begin
      if (!rst_n) lf <= 8'h5A;
      else        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected writes as the design issues them
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_gnt) begin
         req_cnt++;
         if (mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
            if (exp_a.size() == 0) begin
               total++; bad++;
               $display("FAIL R5/R7/R8 unexpected write actual=%h:%h expected=none",
                        mem_addr, mem_wdata);
            end else begin
               chk("R5/R7/R8 write addr", 32'(mem_addr), exp_a.pop_front());
               chk("R5/R7/R8 write data", mem_wdata, exp_d.pop_front());
            end
         end
      end
   end

   task automatic push(input logic [31:0] a, input logic [31:0] d);
      exp_a.push_back(a);
      exp_d.push_back(d);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(input int base, input logic [31:0] c0, input logic [31:0] c1,
                           input logic [31:0] s, input logic [31:0] dd, input logic [31:0] nx);
      mem[base/4 + 0] = c0; mem[base/4 + 1] = c1; mem[base/4 + 2] = s;
      mem[base/4 + 3] = 0;  mem[base/4 + 4] = dd; mem[base/4 + 5] = 0;
      mem[base/4 + 6] = 0;  mem[base/4 + 7] = nx;
   endtask

   // driver: expected copy beats per R5
   task automatic exp_copy(input int s, input int d, input int n);
      for (int k = 0; k < (n + 3) / 4; k++) push(32'(d + 4 * k), mem[(s + 4 * k) / 4]);
   endtask

   task automatic wait_halt();
      logic [31:0] v;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 5000; i++) begin
         rd(3'd4, v);
         if (v[0]) break;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i * 32'h111);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd4, v); chk("R1 status", v, 32'd1);
      rd(3'd3, v); chk("R1 pending", v, 32'd0);
      rd(3'd5, v); chk("R1 remaining", v, 32'd0);
      chk("R1 irq", 32'(irq_o), 32'd0);

      // chain 1: D0 wb=1, D1 ie+clrv+wb=2 count 10, D2 invalid
      put_desc(32'h000, 32'h8000_0001, 32'd8,  32'h100, 32'h200, 32'd1);
      put_desc(32'h020, 32'h8000_0106, 32'd10, 32'h120, 32'h240, 32'd2);
      put_desc(32'h040, 32'h0000_0000, 32'd4,  32'h300, 32'h304, 32'd0);

      // R2 kick while disabled: nothing happens
      wr(3'd1, 32'h0);
      wr(3'd2, 32'h1234);
      repeat (20) @(negedge clk);
      chk("R2 no request when disabled", 32'(req_cnt), 32'd0);
      rd(3'd4, v); chk("R2 still halted", v, 32'd1);

      exp_copy(32'h100, 32'h200, 8);
      push(32'h018, 32'd6);                       // R7 mode 1 live status
      exp_copy(32'h120, 32'h240, 10);             // R5 partial last beat
      push(32'h038, 32'h0000_0106);               // R7 mode 2
      push(32'h020, 32'h0000_0106);               // R8 clear-valid
      wr(3'd0, 32'h1);
      wr(3'd2, 32'h0);
      wait_halt();
      chk("R5/R7/R8 chain 1 drained", 32'(exp_a.size()), 32'd0);
      rd(3'd4, v); chk("R6 halted, flags clear", v, 32'd1);
      rd(3'd1, v); chk("R6/R10 pointer at invalid descriptor", v, 32'h040);
      rd(3'd3, v); chk("R9 pending set", v, 32'd1);
      chk("R9 irq with enable", 32'(irq_o), 32'd1);
      wr(3'd3, 32'h0);
      rd(3'd3, v); chk("R9 pending cleared", v, 32'd0);
      chk("R9 irq cleared", 32'(irq_o), 32'd0);

      // chain 2: D3 count 0 wb=3, D4 wb=0 no ie, then D2 invalid again
      put_desc(32'h060, 32'h8000_0003, 32'd0, 32'h000, 32'h000, 32'd4);
      put_desc(32'h080, 32'h8000_0000, 32'd4, 32'h140, 32'h280, 32'd2);
      push(32'h078, 32'd0);                       // R7 mode 3, R5 zero count
      exp_copy(32'h140, 32'h280, 4);              // R7 mode 0 adds nothing
      wr(3'd1, 32'h060);
      wr(3'd2, 32'h1);
      wait_halt();
      chk("R5/R7 chain 2 drained", 32'(exp_a.size()), 32'd0);
      rd(3'd1, v); chk("R10 link decode back to invalid", v, 32'h040);
      rd(3'd3, v); chk("R9 pending set again", v, 32'd1);
      chk("R9 irq gated by enable bit", 32'(irq_o), 32'd0);
      rd(3'd5, v); chk("R10 remaining zero when idle", v, 32'd0);
      chk("R4 first fetched word is command", mem[32'h020 / 4], 32'h0000_0106);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule